// File: doc/BRIEF.md
# Serial 1101 Pattern Recognizer

This block watches a one-bit serial stream and flags each occurrence of the bit pattern 1101. One bit is taken on every rising clock edge. The flag is a Mealy-style output: it rises combinationally during the cycle in which the last bit of the pattern is on the input, before that bit is clocked in. Occurrences may share bits, so the closing 1 of one match can open the next.

The recognizer holds its history in a two-bit state register. The state codes form a Gray sequence along the path toward a match. The next-state and flag logic are small sum-of-products expressions held in package functions. A synchronous, active-high reset returns the machine to its idle state and holds the flag low.

Top module: `seqdet_1101`

## Requirements
- R1: `bit_in` is sampled only at the rising edge of `clk`. The state register uses these codes: idle = 2'b00, seen "1" = 2'b01, seen "11" = 2'b11, seen "110" = 2'b10.
- R2: While `rst` is high at a rising edge, the machine enters idle. `hit` is 0 for as long as `rst` is high, whatever `bit_in` is.
- R3: Outside reset, `hit` is 1 in a cycle exactly when `bit_in` is 1 and the three bits sampled at the three preceding edges since reset were 1, 1, 0, oldest first. Otherwise `hit` is 0.
- R4: Matches overlap. After a match, the closing 1 counts as the first bit of a new pattern, so the stream 1101101 raises `hit` twice.
- R5: A run of consecutive 1s keeps the "11" history. Any number of 1s followed by 0 and then 1 produces exactly one `hit`.
- R6: A 0 arriving after a single 1, or after "110", discards the history. The stream 1001 produces no `hit`.
- R7: `hit` follows a change of `bit_in` within the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_in | input | 1 | Serial data bit |
| hit | output | 1 | Combinational pattern-complete flag |

## Verification
The bound checker checks the following on every edge:
- reset leads to idle, and `hit` stays low while `rst` is high;
- `hit` never rises outside the "110" state with a 1 on the input;
- every match is followed by the seen-"1" state;
- the 0-after-single-1 restart and the run-of-1s hold follow their transitions.

Some properties only the bench's scenarios can show. These are equivalence with the four-bit window over long random streams, the exact count of overlapping hits in directed streams, and the same-cycle response of `hit` to an input change.

// File: rtl/seqdet_pkg.sv
package seqdet_pkg;

  localparam int ST_W = 2;

  typedef enum logic [ST_W-1:0] {
    ST_IDLE   = 2'b00,
    ST_ONE    = 2'b01,
    ST_ONEONE = 2'b11,
    ST_ONE10  = 2'b10
  } seq_st_t;

  // High state bit: set when low bit is set and either high bit or input is set
  function automatic logic nxt_hi(input logic hi, input logic lo, input logic din);
    return (hi & lo) | (din & lo);
  endfunction

  // Low state bit simply records the incoming bit
  function automatic logic nxt_lo(input logic din);
    return din;
  endfunction

  // Match: in the "110" code with a 1 arriving
  function automatic logic match_fn(input logic hi, input logic lo, input logic din);
    return din & hi & ~lo;
  endfunction

endpackage

// File: rtl/seqdet_next.sv
module seqdet_next
  import seqdet_pkg::*;
(
  input  logic [ST_W-1:0] cur_st,
  input  logic            din,
  output logic [ST_W-1:0] nxt_st
);

  always_comb begin
    nxt_st[1] = nxt_hi(cur_st[1], cur_st[0], din);
    nxt_st[0] = nxt_lo(din);
  end

endmodule

// File: rtl/seqdet_flag.sv
module seqdet_flag
  import seqdet_pkg::*;
(
  input  logic [ST_W-1:0] cur_st,
  input  logic            din,
  input  logic            rst,
  output logic            match_ev,
  output logic            flag
);

  always_comb begin
    match_ev = match_fn(cur_st[1], cur_st[0], din);
    flag     = match_ev & ~rst;
  end

endmodule

// File: rtl/seqdet_sreg.sv
module seqdet_sreg
  import seqdet_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [ST_W-1:0] d,
  output logic [ST_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= ST_IDLE;
    else     q <= d;
  end

endmodule

// File: rtl/seqdet_1101.sv
module seqdet_1101
  import seqdet_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic bit_in,
  output logic hit
);

  logic [ST_W-1:0] state_q;
  logic [ST_W-1:0] state_d;
  logic            match_ev;

  seqdet_next u_next (
    .cur_st (state_q),
    .din    (bit_in),
    .nxt_st (state_d)
  );

  seqdet_sreg u_sreg (
    .clk (clk),
    .rst (rst),
    .d   (state_d),
    .q   (state_q)
  );

  seqdet_flag u_flag (
    .cur_st   (state_q),
    .din      (bit_in),
    .rst      (rst),
    .match_ev (match_ev),
    .flag     (hit)
  );

endmodule

// File: rtl/seqdet_1101_chk.sv
module seqdet_1101_chk
  import seqdet_pkg::*;
(
  input logic            clk,
  input logic            rst,
  input logic            bit_in,
  input logic            hit,
  input logic [ST_W-1:0] state_q
);

  AST_RESET_IDLE: assert property (@(posedge clk) rst |=> state_q == ST_IDLE); // R2

  AST_NO_HIT_IN_RESET: assert property (@(posedge clk) rst |-> !hit); // R2

  AST_HIT_ONLY_AFTER_110: assert property (@(posedge clk) disable iff (rst)
    hit |-> (state_q == ST_ONE10 && bit_in)); // R3

  AST_OVERLAP_RESTART: assert property (@(posedge clk) disable iff (rst)
    hit |=> state_q == ST_ONE); // R4

  AST_RUN_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ONEONE && bit_in) |=> state_q == ST_ONEONE); // R5

  AST_ZERO_DROPS: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_ONE && !bit_in) |=> state_q == ST_IDLE); // R6

endmodule

bind seqdet_1101 seqdet_1101_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .bit_in  (bit_in),
  .hit     (hit),
  .state_q (state_q)
);

// File: tb/seqdet_1101_tb.sv
module seqdet_1101_tb;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_in = 1'b0;
  logic hit;

  int n_chk = 0;
  int n_err = 0;
  int n_hits = 0;
  logic [2:0] win = 3'b000;
  int fill = 0;

  seqdet_1101 u_dut (.clk(clk), .rst(rst), .bit_in(bit_in), .hit(hit));

  always #5 clk = ~clk;

  function automatic logic expect_hit(input logic [2:0] w, input int f, input logic b, input logic r);
    if (r) return 1'b0;
    return (f >= 3) && (w == 3'b110) && b;
  endfunction

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: hit=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic b, input string req);
    @(negedge clk);
    bit_in = b;
    #1;
    check(req, hit, expect_hit(win, fill, b, rst));
    if (hit === 1'b1) n_hits++;
    @(posedge clk);
    if (rst) begin
      win  = 3'b000;
      fill = 0;
    end else begin
      win = {win[1:0], b};
      if (fill < 3) fill++;
    end
  endtask

  task automatic feed(input logic [15:0] pat, input int len, input string req);
    for (int i = len - 1; i >= 0; i--) step(pat[i], req);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    step(1'b1, "R2");
    step(1'b0, "R2");
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    #200000;
    n_chk++;
    n_err++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    // R2: reset state, hit low during reset even with bit_in high
    step(1'b1, "R2");
    step(1'b1, "R2");
    do_reset();

    // R4: overlapping stream 1101101 gives two hits
    n_hits = 0;
    feed(16'b1101101, 7, "R4");
    check("R4 count", n_hits == 2, 1'b1);
    do_reset();

    // R5: long run of ones then 0 1 gives one hit
    n_hits = 0;
    feed(16'b1111101, 7, "R5");
    check("R5 count", n_hits == 1, 1'b1);
    do_reset();

    // R6: 1001 and 11001 give no hit
    n_hits = 0;
    feed(16'b1001, 4, "R6");
    feed(16'b11001, 5, "R6");
    check("R6 count", n_hits == 0, 1'b0 == 1'b0 ? 1'b1 : 1'b0);
    do_reset();

    // R7: same-cycle response in the "110" state
    feed(16'b110, 3, "R3");
    @(negedge clk);
    bit_in = 1'b0;
    #1;
    check("R7", hit, 1'b0);
    bit_in = 1'b1;
    #1;
    check("R7", hit, 1'b1);
    bit_in = 1'b0;
    #1;
    check("R7", hit, 1'b0);
    @(posedge clk);
    win = {win[1:0], 1'b0};
    do_reset();

    // R2: reset in mid-pattern discards history
    feed(16'b110, 3, "R3");
    @(negedge clk);
    rst = 1'b1;
    step(1'b1, "R2");
    @(negedge clk);
    rst = 1'b0;
    step(1'b1, "R2");

    // R1/R3: long random streams against the window model
    void'($urandom(32'd4242));
    for (int i = 0; i < 4000; i++) begin
      logic b;
      b = (($urandom % 8) < 5);
      step(b, "R3");
      if (i == 2000) begin
        do_reset();
      end
    end

    // R3: a few more directed edges: 0110 1 and 1101 tail with zeros
    do_reset();
    feed(16'b01101, 5, "R3");
    feed(16'b1101000, 7, "R3");

    finish_run();
  end

endmodule